// File: doc/BRIEF.md
# Ring Buffer Pointer and Occupancy Tracker

This block holds the two pointers of a byte ring buffer that serves one serial-port DMA channel, and it derives from them how full the ring is. Each pointer is an offset into the ring plus a lap bit that flips every time the pointer passes the end of the ring. Because of the lap bit, a completely full ring and an empty ring can be told apart without giving up a slot. Software loads either pointer directly. The transfer engine sends a one-byte advance strobe. In the receive direction the strobe moves the write pointer, because the device is filling the ring. In the transmit direction it moves the read pointer, because the device is draining the ring.

Two counts are derived from the pointers. The filled count is the bytes the consumer side may take: software in receive mode, hardware in transmit mode. The free count is the space the producer side may use. A sticky interrupt flag compares one of these counts with a programmed level. Receive compares the filled count; transmit compares the free count. The flag is gated by an enable bit to form the interrupt output. In transmit mode, hardware drops the enable by itself once enough space has opened up. Typical levels are three quarters of the ring length for receive and the whole length for transmit.

All control pins are plain levels or single-cycle strobes sampled on the rising clock edge. The block moves no data, so it has no valid/ready stream interface, and the advance strobe has no back-pressure: a strobe that cannot be honoured is dropped.

Top module: `ring_occupancy_tracker`

## Requirements
- R1: After reset both pointers read 0, and the interrupt flag, the enable and the interrupt output are 0.
- R2: A pointer is OFS_W+1 bits wide. Bits OFS_W-1:0 are the byte offset and bit OFS_W (bit 16 by default) is the lap bit. When an advance makes the offset equal to the ring length, the pointer becomes offset 0 with the lap bit inverted.
- R3: The filled count is (write offset − read offset) modulo 2^OFS_W. The ring length is added when the two lap bits differ. The free count is the ring length minus the filled count. Both are visible on the cycle after the pointers change.
- R4: With dir_rx=1 the advance strobe moves only the write pointer. With dir_rx=0 it moves only the read pointer. The pointer updates on the edge that samples the strobe.
- R5: In receive mode, an advance strobe is dropped while the filled count equals a nonzero ring length, so the write pointer does not overrun the read pointer.
- R6: In transmit mode, an advance strobe is dropped while the filled count is 0. With a ring length of 0, strobes are dropped in both directions.
- R7: A pointer load takes ptr_wdata on the next edge. A load to the pointer that the strobe would move wins over the strobe in the same cycle. A load to the other pointer and an advance in the same cycle both take effect.
- R8: The flag sets on the edge after the condition holds. In receive mode the condition is filled count ≥ level. In transmit mode it is free count ≥ level.
- R9: The flag stays set until irq_flag_clr is pulsed. A clear in a cycle where the condition still holds leaves the flag set.
- R10: irq_en_set sets the enable and irq_en_clr clears it; set wins if both are pulsed. The interrupt output is high exactly when the flag and the enable are both high.
- R11: In transmit mode, while free count ≥ level, the enable is cleared on the next edge, overriding irq_en_set.
- R12: Loading the read pointer with the current write pointer value empties the ring in one step: the filled count becomes 0 and the free count becomes the ring length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ring_len | input | OFS_W | Ring length in bytes |
| irq_level | input | OFS_W | Level compared with the filled or free count |
| dir_rx | input | 1 | 1 = receive direction, 0 = transmit direction |
| wptr_load | input | 1 | Load the write pointer from ptr_wdata |
| rptr_load | input | 1 | Load the read pointer from ptr_wdata |
| ptr_wdata | input | OFS_W+1 | Pointer value for loads (lap bit on top) |
| hw_step | input | 1 | One-byte advance strobe from the transfer engine |
| irq_en_set | input | 1 | Set the interrupt enable |
| irq_en_clr | input | 1 | Clear the interrupt enable |
| irq_flag_clr | input | 1 | Clear the sticky interrupt flag |
| wptr | output | OFS_W+1 | Write pointer readback |
| rptr | output | OFS_W+1 | Read pointer readback |
| fill_bytes | output | OFS_W | Filled count |
| space_bytes | output | OFS_W | Free count |
| irq_flag | output | 1 | Sticky interrupt flag |
| irq_en | output | 1 | Interrupt enable |
| irq | output | 1 | Interrupt output, flag AND enable |

## Verification
The cases of interest are two functions that land in the same cycle. One is a software pointer load in the same cycle as a hardware advance strobe. The other is a flag clear or enable set in the same cycle as the interrupt condition being true. Directed steps provoke each collision on purpose: a read-pointer load during a receive strobe, a write-pointer load that overrides a receive strobe, a flag clear while the level is still met, and an enable set while the transmit auto-clear is active. The random phase then makes these overlaps often. Every cycle the pointers, both counts, the flag, the enable and the interrupt are compared with a bench model of the requirements.

// File: rtl/ring_trk_pkg.sv
package ring_trk_pkg;
  // direction of the channel as seen by the tracker
  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } ring_dir_e;

  // role of each pointer instance in the generate array
  localparam int PTR_WR  = 0;
  localparam int PTR_RD  = 1;
  localparam int NUM_PTR = 2;
endpackage

// File: rtl/ring_ptr_reg.sv
module ring_ptr_reg #(
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFS_W-1:0] len,
  input  logic             sw_load,
  input  logic [OFS_W:0]   sw_value,
  input  logic             step_en,
  output logic [OFS_W:0]   ptr
);
  localparam int PTR_W = OFS_W + 1;

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_adv;
  logic [OFS_W-1:0] off_inc;

  // one-byte advance with lap toggle at the ring end
  always_comb begin
    off_inc = ptr_q[OFS_W-1:0] + 1'b1;
    if (off_inc == len) ptr_adv = {~ptr_q[OFS_W], {OFS_W{1'b0}}};
    else                ptr_adv = {ptr_q[OFS_W], off_inc};
  end

  // software load has priority over the hardware step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr_q <= '0;
    else if (sw_load)  ptr_q <= sw_value;
    else if (step_en)  ptr_q <= ptr_adv;
  end

  assign ptr = ptr_q;

  // last slot of the ring rolls to offset 0 and flips the lap bit
  assert_lap_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !sw_load && ((ptr_q[OFS_W-1:0] + 1'b1) == len))
    |=> (ptr_q[OFS_W-1:0] == '0) && (ptr_q[OFS_W] != $past(ptr_q[OFS_W])));

  // a load always lands exactly
  assert_load_exact_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_load |=> (ptr_q == $past(sw_value)));
endmodule

// File: rtl/ring_fill_calc.sv
module ring_fill_calc #(
  parameter int OFS_W = 16
) (
  input  logic [OFS_W:0]   wr_ptr,
  input  logic [OFS_W:0]   rd_ptr,
  input  logic [OFS_W-1:0] len,
  output logic [OFS_W-1:0] fill,
  output logic [OFS_W-1:0] space,
  output logic             full,
  output logic             empty
);
  logic [OFS_W-1:0] off_diff;
  logic             lap_differs;

  always_comb begin
    off_diff    = wr_ptr[OFS_W-1:0] - rd_ptr[OFS_W-1:0];
    lap_differs = wr_ptr[OFS_W] ^ rd_ptr[OFS_W];
    fill        = lap_differs ? (off_diff + len) : off_diff;
    space       = len - fill;
    full        = (len != '0) && (fill == len);
    empty       = (fill == '0);
  end
endmodule

// File: rtl/ring_irq_ctrl.sv
module ring_irq_ctrl #(
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_rx,
  input  logic [OFS_W-1:0] fill,
  input  logic [OFS_W-1:0] space,
  input  logic [OFS_W-1:0] level,
  input  logic             flag_clr,
  input  logic             en_set,
  input  logic             en_clr,
  output logic             flag,
  output logic             en,
  output logic             irq
);
  import ring_trk_pkg::*;

  ring_dir_e dir;
  logic      space_hit;
  logic      fill_hit;
  logic      cond;
  logic      auto_off;
  logic      flag_q;
  logic      en_q;

  always_comb begin
    dir       = ring_dir_e'(dir_rx);
    fill_hit  = (fill >= level);
    space_hit = (space >= level);
    cond      = (dir == DIR_RX) ? fill_hit : space_hit;
    auto_off  = (dir == DIR_TX) && space_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      flag_q <= cond | (flag_q & ~flag_clr);
      if (auto_off)    en_q <= 1'b0;
      else if (en_set) en_q <= 1'b1;
      else if (en_clr) en_q <= 1'b0;
    end
  end

  assign flag = flag_q;
  assign en   = en_q;
  assign irq  = flag_q & en_q;

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);

  assert_tx_en_autoclr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_rx && (space >= level)) |=> !en_q);

  assert_flag_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_rx && (fill >= level)) |=> flag_q);
endmodule

// File: rtl/ring_occupancy_tracker.sv
module ring_occupancy_tracker #(
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFS_W-1:0] ring_len,
  input  logic [OFS_W-1:0] irq_level,
  input  logic             dir_rx,
  input  logic             wptr_load,
  input  logic             rptr_load,
  input  logic [OFS_W:0]   ptr_wdata,
  input  logic             hw_step,
  input  logic             irq_en_set,
  input  logic             irq_en_clr,
  input  logic             irq_flag_clr,
  output logic [OFS_W:0]   wptr,
  output logic [OFS_W:0]   rptr,
  output logic [OFS_W-1:0] fill_bytes,
  output logic [OFS_W-1:0] space_bytes,
  output logic             irq_flag,
  output logic             irq_en,
  output logic             irq
);
  import ring_trk_pkg::*;

  localparam int PTR_W = OFS_W + 1;

  logic [NUM_PTR-1:0] load_v;
  logic [NUM_PTR-1:0] step_v;
  logic [PTR_W-1:0]   ptr_v [NUM_PTR];
  logic               len_ok;
  logic               full;
  logic               empty;

  // strobe steers to the producer pointer on receive, consumer on transmit
  always_comb begin
    len_ok         = (ring_len != '0);
    load_v[PTR_WR] = wptr_load;
    load_v[PTR_RD] = rptr_load;
    step_v[PTR_WR] = hw_step & len_ok &  dir_rx & ~full;
    step_v[PTR_RD] = hw_step & len_ok & ~dir_rx & ~empty;
  end

  for (genvar k = 0; k < NUM_PTR; k++) begin : g_ptr
    ring_ptr_reg #(.OFS_W(OFS_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .len      (ring_len),
      .sw_load  (load_v[k]),
      .sw_value (ptr_wdata),
      .step_en  (step_v[k]),
      .ptr      (ptr_v[k])
    );
  end

  assign wptr = ptr_v[PTR_WR];
  assign rptr = ptr_v[PTR_RD];

  ring_fill_calc #(.OFS_W(OFS_W)) u_fill (
    .wr_ptr (ptr_v[PTR_WR]),
    .rd_ptr (ptr_v[PTR_RD]),
    .len    (ring_len),
    .fill   (fill_bytes),
    .space  (space_bytes),
    .full   (full),
    .empty  (empty)
  );

  ring_irq_ctrl #(.OFS_W(OFS_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .dir_rx   (dir_rx),
    .fill     (fill_bytes),
    .space    (space_bytes),
    .level    (irq_level),
    .flag_clr (irq_flag_clr),
    .en_set   (irq_en_set),
    .en_clr   (irq_en_clr),
    .flag     (irq_flag),
    .en       (irq_en),
    .irq      (irq)
  );

  assert_rx_no_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_rx && full && hw_step && !wptr_load) |=> $stable(wptr));

  assert_tx_no_underrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_rx && empty && hw_step && !rptr_load) |=> $stable(rptr));

  assert_rx_rptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_rx && !rptr_load) |=> $stable(rptr));

  assert_tx_wptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_rx && !wptr_load) |=> $stable(wptr));
endmodule

// File: tb/test_ring_occupancy_tracker.sv
`timescale 1ns/1ps
module test_ring_occupancy_tracker;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] ring_len = '0;
  logic [W-1:0] irq_level = '0;
  logic         dir_rx = 1'b0;
  logic         wptr_load = 1'b0;
  logic         rptr_load = 1'b0;
  logic [W:0]   ptr_wdata = '0;
  logic         hw_step = 1'b0;
  logic         irq_en_set = 1'b0;
  logic         irq_en_clr = 1'b0;
  logic         irq_flag_clr = 1'b0;
  logic [W:0]   wptr, rptr;
  logic [W-1:0] fill_bytes, space_bytes;
  logic         irq_flag, irq_en, irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // model state
  logic [W:0] m_wr = '0, m_rd = '0;
  logic       m_flag = 1'b0, m_en = 1'b0;

  always #2.5 clk = ~clk;

  ring_occupancy_tracker #(.OFS_W(W)) i_ring_occupancy_tracker (
    .clk, .rst_n, .ring_len, .irq_level, .dir_rx, .wptr_load, .rptr_load,
    .ptr_wdata, .hw_step, .irq_en_set, .irq_en_clr, .irq_flag_clr,
    .wptr, .rptr, .fill_bytes, .space_bytes, .irq_flag, .irq_en, .irq
  );

  function automatic logic [W-1:0] f_fill(logic [W:0] wr, logic [W:0] rd, logic [W-1:0] len);
    logic [W-1:0] d = wr[W-1:0] - rd[W-1:0];
    if (wr[W] != rd[W]) d = d + len;
    return d;
  endfunction

  function automatic logic [W:0] f_adv(logic [W:0] p, logic [W-1:0] len);
    logic [W-1:0] o = p[W-1:0] + 1'b1;
    if (o == len) return {~p[W], {W{1'b0}}};
    return {p[W], o};
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(string ptr_req);
    logic [W-1:0] f = f_fill(m_wr, m_rd, ring_len);
    chk(ptr_req, "wptr", wptr, m_wr);
    chk(ptr_req, "rptr", rptr, m_rd);
    chk("R3", "fill", fill_bytes, f);
    chk("R3", "space", space_bytes, W'(ring_len - f));
    chk("R8", "flag", irq_flag, m_flag);
    chk("R10", "enable", irq_en, m_en);
    chk("R10", "irq", irq, m_flag & m_en);
  endtask

  // apply current inputs for one edge, advance the model, compare at negedge
  task automatic step(string ptr_req);
    logic [W-1:0] f = f_fill(m_wr, m_rd, ring_len);
    logic [W-1:0] s = ring_len - f;
    logic full = (ring_len != 0) && (f == ring_len);
    logic empty = (f == 0);
    logic hit = dir_rx ? (f >= irq_level) : (s >= irq_level);
    logic auto_off = !dir_rx && (s >= irq_level);
    logic [W:0] n_wr = m_wr, n_rd = m_rd;
    logic n_en = m_en;
    if (wptr_load) n_wr = ptr_wdata;
    else if (hw_step && dir_rx && !full && ring_len != 0) n_wr = f_adv(m_wr, ring_len);
    if (rptr_load) n_rd = ptr_wdata;
    else if (hw_step && !dir_rx && !empty && ring_len != 0) n_rd = f_adv(m_rd, ring_len);
    if (auto_off) n_en = 1'b0;
    else if (irq_en_set) n_en = 1'b1;
    else if (irq_en_clr) n_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    m_wr = n_wr; m_rd = n_rd; m_en = n_en;
    m_flag = hit | (m_flag & ~irq_flag_clr);
    compare_all(ptr_req);
    wptr_load = 0; rptr_load = 0; hw_step = 0;
    irq_en_set = 0; irq_en_clr = 0; irq_flag_clr = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin : stim
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R1", "wptr at reset", wptr, 0);
    chk("R1", "rptr at reset", rptr, 0);
    chk("R1", "flag at reset", irq_flag, 0);
    chk("R1", "enable at reset", irq_en, 0);
    chk("R1", "irq at reset", irq, 0);
    rst_n = 1'b1;

    // receive: length 4, level 3
    dir_rx = 1; ring_len = 4; irq_level = 3;
    irq_en_set = 1; step("R4");
    for (int i = 0; i < 4; i++) begin hw_step = 1; step("R4"); end
    chk("R2", "wptr lapped to offset 0", wptr, 17'h10000);
    chk("R3", "fill full", fill_bytes, 4);
    chk("R10", "irq asserted", irq, 1);
    hw_step = 1; step("R5");
    chk("R5", "strobe dropped when full", wptr, 17'h10000);
    // consume all in one step while flag sticky
    rptr_load = 1; ptr_wdata = 17'h10000; step("R12");
    chk("R12", "fill after consume", fill_bytes, 0);
    chk("R12", "space after consume", space_bytes, 4);
    chk("R9", "flag held after drain", irq_flag, 1);
    irq_flag_clr = 1; step("R9");
    chk("R9", "flag cleared", irq_flag, 0);
    // clear while condition still holds
    for (int i = 0; i < 3; i++) begin hw_step = 1; step("R4"); end
    irq_flag_clr = 1; step("R9");
    chk("R9", "clear loses to live condition", irq_flag, 1);
    // same-cycle load of other pointer plus strobe
    rptr_load = 1; ptr_wdata = 17'h10002; hw_step = 1; step("R7");
    chk("R7", "rptr load with strobe", rptr, 17'h10002);
    chk("R7", "wptr advanced with load", wptr, 17'h00000);
    // load of the stepped pointer wins over strobe
    wptr_load = 1; ptr_wdata = 17'h10003; hw_step = 1; step("R7");
    chk("R7", "wptr load wins", wptr, 17'h10003);

    // transmit: length 4, level 4
    dir_rx = 0; irq_level = 4;
    wptr_load = 1; rptr_load = 1; ptr_wdata = 0; step("R7");
    irq_en_set = 1; step("R11");
    chk("R11", "enable auto-cleared over set", irq_en, 0);
    hw_step = 1; step("R6");
    chk("R6", "strobe dropped when empty", rptr, 0);
    wptr_load = 1; ptr_wdata = 17'h00003; step("R7");
    irq_flag_clr = 1; irq_en_set = 1; step("R10");
    chk("R10", "enable set", irq_en, 1);
    chk("R8", "flag cleared below level", irq_flag, 0);
    for (int i = 0; i < 3; i++) begin hw_step = 1; step("R4"); end
    chk("R3", "space back to full length", space_bytes, 4);
    step("R8");
    chk("R8", "tx flag set", irq_flag, 1);
    chk("R11", "enable dropped by hardware", irq_en, 0);
    // zero length drops strobes
    ring_len = 0; dir_rx = 1; hw_step = 1; step("R6");
    chk("R6", "zero length rx strobe dropped", wptr, 3);

    // random phase
    for (int seg = 0; seg < 30; seg++) begin
      ring_len = W'($urandom_range(1, 24));
      irq_level = W'($urandom_range(0, ring_len));
      dir_rx = $urandom_range(0, 1) == 1;
      wptr_load = 1; rptr_load = 1; ptr_wdata = 0; step("R7");
      for (int c = 0; c < 150; c++) begin
        hw_step = $urandom_range(0, 99) < 55;
        if ($urandom_range(0, 99) < 8) begin
          if (dir_rx) begin
            rptr_load = 1;
            ptr_wdata = ($urandom_range(0, 1) == 1) ? m_wr : m_rd;
          end else begin
            wptr_load = 1;
            ptr_wdata = {1'($urandom_range(0, 1)), W'($urandom_range(0, ring_len - 1))};
          end
        end
        irq_en_set = $urandom_range(0, 99) < 10;
        irq_en_clr = $urandom_range(0, 99) < 10;
        irq_flag_clr = $urandom_range(0, 99) < 15;
        step("R4");
      end
    end

    done = 1;
    finish_run();
  end
endmodule